// File: doc/BRIEF.md
# Descriptor-Chained Stream-to-Memory DMA Channel

This block takes a 32-bit stream and writes it into local memory, one word per memory request. It is driven by a table of 16 buffer descriptors, which a configuration port writes one whole descriptor per cycle. A descriptor carries the start word address, the word count, the address step between words, the index of a follow-on descriptor with a flag that enables the hop, and an optional semaphore lock number. When a lock is enabled, the channel acquires it before it accepts stream data and releases it after the last word is stored.

A pulse on `start_i` picks the first descriptor. The channel then runs descriptor after descriptor along the chain. A descriptor ends when its word count is used up or when a word arrives with TLAST set, whichever happens first. When a descriptor without the chain flag completes, the channel pulses `done_o` and goes idle. The stream is stalled (TREADY low) while a lock request or a memory write is outstanding. The channel therefore stores at most one word every two cycles.

Top module: `s2mm_chain_dma`

## Requirements
- R1: After reset `busy_o`, `s_tready_o`, `mem_req_o`, `lock_acq_o`, `lock_rel_o` and `done_o` are all low.
- R2: A cycle with `cfg_we_i` high stores `cfg_desc_i` at entry `cfg_idx_i`. The fields are: bits [15:0] start word address, [27:16] word count minus one, [31:28] follow-on index, bit 32 chain enable, bit 33 lock enable, [37:34] lock number, [41:38] address step.
- R3: The words of one descriptor go to addresses base, base+step, base+2*step and so on, in the order they arrive on the stream, with the stream data unchanged.
- R4: Without TLAST, a descriptor writes exactly word-count words and then moves on.
- R5: A word that carries TLAST is stored and ends the descriptor. Its remaining count is dropped and no further address of that descriptor is written.
- R6: With chain enable set, the follow-on descriptor is loaded when the current one completes and runs from its own start address.
- R7: When a descriptor with chain enable clear completes, `done_o` is high for exactly one cycle and `busy_o` is low in the following cycle.
- R8: For a descriptor with lock enable set, `lock_acq_o` rises with `lock_id_o` equal to the lock number before any word is accepted. Both stay unchanged until `lock_gnt_i`, and `s_tready_o` stays low until then.
- R9: After the last word of a locked descriptor is accepted by memory, `lock_rel_o` pulses for one cycle with `lock_id_o` equal to the lock number.
- R10: While `mem_req_o` is high, `s_tready_o` is low, and address and data hold until `mem_gnt_i` is seen.
- R11: `start_i` has no effect while `busy_o` is high.
- R12: A descriptor with lock enable clear never raises `lock_acq_o` or `lock_rel_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Descriptor write strobe |
| cfg_idx_i | input | 4 | Descriptor entry to write |
| cfg_desc_i | input | 42 | Descriptor contents |
| start_i | input | 1 | Start pulse |
| start_idx_i | input | 4 | First descriptor of the chain |
| busy_o | output | 1 | Channel active |
| done_o | output | 1 | One-cycle pulse at chain end |
| s_tdata_i | input | 32 | Stream data |
| s_tvalid_i | input | 1 | Stream valid |
| s_tlast_i | input | 1 | Stream last marker |
| s_tready_o | output | 1 | Stream ready |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_gnt_i | input | 1 | Memory accepts the write this cycle |
| lock_acq_o | output | 1 | Lock acquire request |
| lock_rel_o | output | 1 | Lock release pulse |
| lock_id_o | output | 4 | Lock number for request or release |
| lock_gnt_i | input | 1 | Lock acquire granted |

## Verification
The assertions assume that the memory and the lock service only grant while a request is up. They also assume that the stream is not driven with data the channel cannot take. The bench raises `mem_gnt_i` freely, even when no request is pending, because the channel ignores it outside a write. It raises `lock_gnt_i` only after it has seen `lock_acq_o` for three cycles. Memory grants are either given every cycle or toggled, so that stalled writes appear. Each descriptor's length is at least one word, since the length field holds the count minus one.

// File: rtl/s2mm_pkg.sv
package s2mm_pkg;
  parameter int ADDR_W = 16;
  parameter int LEN_W  = 12;
  parameter int IDX_W  = 4;
  parameter int LOCK_W = 4;
  parameter int STR_W  = 4;
  parameter int DATA_W = 32;

  typedef struct packed {
    logic [STR_W-1:0]  stride;
    logic [LOCK_W-1:0] lock_id;
    logic              lock_en;
    logic              chain;
    logic [IDX_W-1:0]  nxt;
    logic [LEN_W-1:0]  len_m1;
    logic [ADDR_W-1:0] base;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_ACQ, ST_XFER, ST_WRITE, ST_REL, ST_NEXT
  } st_e;
endpackage

// File: rtl/s2mm_bd_table.sv
module s2mm_bd_table
  import s2mm_pkg::*;
#(
  parameter int N_BD = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [$clog2(N_BD)-1:0]  widx_i,
  input  desc_t                    wdesc_i,
  input  logic [$clog2(N_BD)-1:0]  ridx_i,
  output desc_t                    rdesc_o
);
  desc_t tbl_q [N_BD];

  for (genvar g = 0; g < N_BD; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           tbl_q[g] <= '0;
      else if (we_i && widx_i == g[$clog2(N_BD)-1:0]) tbl_q[g] <= wdesc_i;
    end
  end

  assign rdesc_o = tbl_q[ridx_i];
endmodule

// File: rtl/s2mm_addr_gen.sv
module s2mm_addr_gen
  import s2mm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  input  logic [STR_W-1:0]  stride_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= base_i;
    else if (step_i) addr_o <= addr_o + ADDR_W'(stride_i);
  end

  // R3: a load and a step never coincide, so no address is skipped
  assert_no_step_on_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && step_i));
endmodule

// File: rtl/s2mm_fsm.sv
module s2mm_fsm
  import s2mm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  start_idx_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  desc_t             rdesc_i,
  output logic              addr_load_o,
  output logic [ADDR_W-1:0] addr_base_o,
  output logic              addr_step_o,
  output logic [STR_W-1:0]  addr_stride_o,
  output logic              busy_o,
  output logic              done_o,
  input  logic [DATA_W-1:0] s_tdata_i,
  input  logic              s_tvalid_i,
  input  logic              s_tlast_i,
  output logic              s_tready_o,
  output logic              mem_req_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  output logic              lock_acq_o,
  output logic              lock_rel_o,
  output logic [LOCK_W-1:0] lock_id_o,
  input  logic              lock_gnt_i
);
  st_e              st_q;
  logic [IDX_W-1:0] idx_q;
  desc_t            d_q;
  logic [LEN_W-1:0] cnt_q;
  logic             last_q;
  logic [DATA_W-1:0] wd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; idx_q <= '0; d_q <= '0;
      cnt_q <= '0; last_q <= 1'b0; wd_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin idx_q <= start_idx_i; st_q <= ST_LOAD; end
        ST_LOAD: begin
          d_q   <= rdesc_i;
          cnt_q <= '0;
          st_q  <= rdesc_i.lock_en ? ST_ACQ : ST_XFER;
        end
        ST_ACQ:  if (lock_gnt_i) st_q <= ST_XFER;
        ST_XFER: if (s_tvalid_i) begin
          wd_q   <= s_tdata_i;
          last_q <= s_tlast_i || (cnt_q == d_q.len_m1);
          st_q   <= ST_WRITE;
        end
        ST_WRITE: if (mem_gnt_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_q) st_q <= d_q.lock_en ? ST_REL : ST_NEXT;
          else        st_q <= ST_XFER;
        end
        ST_REL:  st_q <= ST_NEXT;
        ST_NEXT: if (d_q.chain) begin idx_q <= d_q.nxt; st_q <= ST_LOAD; end
                 else st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_idx_o      = idx_q;
  assign addr_load_o   = (st_q == ST_LOAD);
  assign addr_base_o   = rdesc_i.base;
  assign addr_step_o   = (st_q == ST_WRITE) && mem_gnt_i;
  assign addr_stride_o = d_q.stride;
  assign busy_o        = (st_q != ST_IDLE);
  assign done_o        = (st_q == ST_NEXT) && !d_q.chain;
  assign s_tready_o    = (st_q == ST_XFER);
  assign mem_req_o     = (st_q == ST_WRITE);
  assign mem_wdata_o   = wd_q;
  assign lock_acq_o    = (st_q == ST_ACQ);
  assign lock_rel_o    = (st_q == ST_REL);
  assign lock_id_o     = d_q.lock_id;

  assert_acq_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_acq_o && !lock_gnt_i |=> lock_acq_o && $stable(lock_id_o));
  assert_done_then_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o && !done_o);
  assert_len_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> cnt_q <= d_q.len_m1);
  assert_rel_after_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_rel_o |-> $past(mem_req_o && mem_gnt_i));
  assert_one_action_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({s_tready_o, mem_req_o, lock_acq_o, lock_rel_o}));
endmodule

// File: rtl/s2mm_chain_dma.sv
module s2mm_chain_dma
  import s2mm_pkg::*;
#(
  parameter int N_BD = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [IDX_W-1:0]        cfg_idx_i,
  input  logic [DESC_W-1:0]       cfg_desc_i,
  input  logic                    start_i,
  input  logic [IDX_W-1:0]        start_idx_i,
  output logic                    busy_o,
  output logic                    done_o,
  input  logic [DATA_W-1:0]       s_tdata_i,
  input  logic                    s_tvalid_i,
  input  logic                    s_tlast_i,
  output logic                    s_tready_o,
  output logic                    mem_req_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [DATA_W-1:0]       mem_wdata_o,
  input  logic                    mem_gnt_i,
  output logic                    lock_acq_o,
  output logic                    lock_rel_o,
  output logic [LOCK_W-1:0]       lock_id_o,
  input  logic                    lock_gnt_i
);
  desc_t             rdesc;
  logic [IDX_W-1:0]  rd_idx;
  logic              a_load, a_step;
  logic [ADDR_W-1:0] a_base;
  logic [STR_W-1:0]  a_stride;

  s2mm_bd_table #(.N_BD(N_BD)) u_tbl (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .widx_i(cfg_idx_i),
    .wdesc_i(desc_t'(cfg_desc_i)), .ridx_i(rd_idx), .rdesc_o(rdesc)
  );

  s2mm_fsm u_fsm (
    .clk_i, .rst_ni, .start_i, .start_idx_i, .rd_idx_o(rd_idx), .rdesc_i(rdesc),
    .addr_load_o(a_load), .addr_base_o(a_base), .addr_step_o(a_step),
    .addr_stride_o(a_stride), .busy_o, .done_o, .s_tdata_i, .s_tvalid_i,
    .s_tlast_i, .s_tready_o, .mem_req_o, .mem_wdata_o, .mem_gnt_i,
    .lock_acq_o, .lock_rel_o, .lock_id_o, .lock_gnt_i
  );

  s2mm_addr_gen u_ag (
    .clk_i, .rst_ni, .load_i(a_load), .base_i(a_base), .step_i(a_step),
    .stride_i(a_stride), .addr_o(mem_addr_o)
  );

  assert_mem_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o));
  assert_start_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);
endmodule

// File: tb/sim_s2mm_chain_dma.sv
`timescale 1ns/1ps
module sim_s2mm_chain_dma;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cfg_we = 0;
  logic [3:0]  cfg_idx = 0;
  logic [41:0] cfg_desc = 0;
  logic        start = 0;
  logic [3:0]  start_idx = 0;
  logic        busy, done;
  logic [31:0] tdata = 0;
  logic        tvalid = 0, tlast = 0, tready;
  logic        mreq;
  logic [15:0] maddr;
  logic [31:0] mwdata;
  logic        gnt_always = 1, gnt_tog = 0;
  logic        mgnt;
  logic        lacq, lrel, lgnt = 0;
  logic [3:0]  lid;

  assign mgnt = gnt_always | gnt_tog;
  always @(posedge clk) gnt_tog <= ~gnt_tog;

  s2mm_chain_dma u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_desc_i(cfg_desc), .start_i(start), .start_idx_i(start_idx),
    .busy_o(busy), .done_o(done), .s_tdata_i(tdata), .s_tvalid_i(tvalid),
    .s_tlast_i(tlast), .s_tready_o(tready), .mem_req_o(mreq), .mem_addr_o(maddr),
    .mem_wdata_o(mwdata), .mem_gnt_i(mgnt), .lock_acq_o(lacq), .lock_rel_o(lrel),
    .lock_id_o(lid), .lock_gnt_i(lgnt)
  );

  int errors = 0, checks = 0;
  logic [31:0] mem [256];
  int wr_cnt = 0, done_cnt = 0, acq_cyc = 0, rel_cnt = 0, rel_id = -1, acq_id = -1;
  int viol_req_rdy = 0, viol_acq_rdy = 0, done_len = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [41:0] mk(input int base, input int words, input int nxt,
                                     input bit chain, input bit lken, input int lkid,
                                     input int stride);
    return {4'(stride), 4'(lkid), lken, chain, 4'(nxt), 12'(words - 1), 16'(base)};
  endfunction

  // port monitors, sampled mid-cycle
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (mreq && mgnt) begin mem[maddr[7:0]] = mwdata; wr_cnt++; end
      if (mreq && tready) viol_req_rdy++;
      if (lacq && tready) viol_acq_rdy++;
      if (lrel) begin rel_cnt++; rel_id = lid; end
      if (done) begin done_cnt++; done_len++; end
      else done_len = 0;
      if (lacq) begin acq_id = lid; acq_cyc++; lgnt = (acq_cyc >= 3); end
      else begin acq_cyc = 0; lgnt = 0; end
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic wr_desc(input int idx, input logic [41:0] d);
    @(negedge clk); cfg_we = 1; cfg_idx = 4'(idx); cfg_desc = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic kick(input int idx);
    @(negedge clk); start = 1; start_idx = 4'(idx);
    @(negedge clk); start = 0;
  endtask

  task automatic send(input logic [31:0] v, input bit last);
    @(negedge clk); tvalid = 1; tdata = v; tlast = last;
    while (!tready) @(negedge clk);
    @(posedge clk);
    @(negedge clk); tvalid = 0; tlast = 0;
  endtask

  task automatic wait_done(input int target);
    while (done_cnt < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!busy && !tready && !mreq && !lacq && !lrel && !done, "R1 reset outputs",
        {busy, tready, mreq, lacq, lrel, done}, 0);
  endtask

  task automatic t_single;
    int w0 = wr_cnt, d0 = done_cnt, r0 = rel_cnt;
    wr_desc(1, mk(16'h10, 4, 0, 0, 0, 0, 1));
    kick(1);
    for (int i = 0; i < 4; i++) send(32'hA000 + 32'(i), 0);
    wait_done(d0 + 1);
    for (int i = 0; i < 4; i++) chk(mem[8'h10 + i] == 32'hA000 + 32'(i), "R3 linear data", mem[8'h10 + i], 32'hA000 + i);
    chk(wr_cnt - w0 == 4, "R4 word count", wr_cnt - w0, 4);
    chk(mem[8'h14] == 32'hDEAD0014, "R4 no extra word", mem[8'h14], 32'hDEAD0014);
    chk(!busy && done_len == 0, "R7 idle after done", busy, 0);
    chk(rel_cnt == r0 && acq_id == -1, "R12 no lock traffic", rel_cnt - r0, 0);
    chk(done_cnt - d0 == 1, "R7 single done pulse", done_cnt - d0, 1);
  endtask

  task automatic t_stride_stall;
    int d0 = done_cnt;
    gnt_always = 0;
    wr_desc(2, mk(16'h40, 3, 0, 0, 0, 0, 3));
    kick(2);
    for (int i = 0; i < 3; i++) send(32'hB000 + 32'(i), 0);
    wait_done(d0 + 1);
    gnt_always = 1;
    for (int i = 0; i < 3; i++) chk(mem[8'h40 + 3 * i] == 32'hB000 + 32'(i), "R3 strided address", mem[8'h40 + 3 * i], 32'hB000 + i);
    chk(mem[8'h41] == 32'hDEAD0041, "R3 gap untouched", mem[8'h41], 32'hDEAD0041);
    chk(viol_req_rdy == 0, "R10 ready low during write", viol_req_rdy, 0);
  endtask

  task automatic t_chain;
    int d0 = done_cnt;
    wr_desc(4, mk(16'h80, 2, 5, 1, 0, 0, 1));
    wr_desc(5, mk(16'h90, 3, 0, 0, 0, 0, 1));
    kick(4);
    for (int i = 0; i < 5; i++) send(32'hC000 + 32'(i), 0);
    wait_done(d0 + 1);
    chk(mem[8'h80] == 32'hC000 && mem[8'h81] == 32'hC001, "R6 first link", mem[8'h81], 32'hC001);
    chk(mem[8'h82] == 32'hDEAD0082, "R4 first link bounded", mem[8'h82], 32'hDEAD0082);
    chk(mem[8'h90] == 32'hC002 && mem[8'h92] == 32'hC004, "R6 second link", mem[8'h92], 32'hC004);
    chk(done_cnt - d0 == 1, "R7 one done per chain", done_cnt - d0, 1);
  endtask

  task automatic t_tlast;
    int d0 = done_cnt;
    wr_desc(7, mk(16'hA0, 6, 8, 1, 0, 0, 1));
    wr_desc(8, mk(16'hB0, 2, 0, 0, 0, 0, 1));
    kick(7);
    send(32'hD000, 0); send(32'hD001, 1);
    send(32'hD002, 0); send(32'hD003, 0);
    wait_done(d0 + 1);
    chk(mem[8'hA1] == 32'hD001, "R5 last word stored", mem[8'hA1], 32'hD001);
    chk(mem[8'hA2] == 32'hDEAD00A2, "R5 remainder dropped", mem[8'hA2], 32'hDEAD00A2);
    chk(mem[8'hB0] == 32'hD002 && mem[8'hB1] == 32'hD003, "R5 next descriptor runs", mem[8'hB0], 32'hD002);
  endtask

  task automatic t_lock;
    int d0 = done_cnt, r0 = rel_cnt;
    wr_desc(9, mk(16'hC0, 3, 0, 0, 1, 11, 1));
    kick(9);
    repeat (2) @(negedge clk);
    chk(lacq && lid == 4'd11, "R8 acquire raised with id", lid, 11);
    chk(wr_cnt >= 0 && mem[8'hC0] == 32'hDEAD00C0, "R8 no write before grant", mem[8'hC0], 32'hDEAD00C0);
    for (int i = 0; i < 3; i++) send(32'hE000 + 32'(i), 0);
    wait_done(d0 + 1);
    chk(viol_acq_rdy == 0, "R8 ready low while acquiring", viol_acq_rdy, 0);
    chk(mem[8'hC2] == 32'hE002, "R8 data after grant", mem[8'hC2], 32'hE002);
    chk(rel_cnt - r0 == 1 && rel_id == 11, "R9 release pulse", rel_id, 11);
  endtask

  task automatic t_start_busy;
    int d0 = done_cnt;
    wr_desc(3, mk(16'hD0, 2, 0, 0, 0, 0, 1));
    wr_desc(6, mk(16'hE0, 2, 0, 0, 0, 0, 1));
    kick(3);
    send(32'hF000, 0);
    kick(6);
    send(32'hF001, 0);
    wait_done(d0 + 1);
    repeat (4) @(negedge clk);
    chk(!busy, "R11 stays idle", busy, 0);
    chk(mem[8'hE0] == 32'hDEAD00E0, "R11 start ignored", mem[8'hE0], 32'hDEAD00E0);
    chk(mem[8'hD1] == 32'hF001, "R11 running chain intact", mem[8'hD1], 32'hF001);
  endtask

  task automatic t_rewrite;
    int d0 = done_cnt;
    wr_desc(1, mk(16'hF0, 1, 0, 0, 0, 0, 1));
    kick(1);
    send(32'h1234, 0);
    wait_done(d0 + 1);
    chk(mem[8'hF0] == 32'h1234, "R2 overwritten descriptor used", mem[8'hF0], 32'h1234);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD0000 + 32'(i);
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_single;
    t_stride_stall;
    t_chain;
    t_tlast;
    t_lock;
    t_start_busy;
    t_rewrite;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule